// File: doc/BRIEF.md
# Dual-Convention Stack Engine

This block owns a 16-bit stack pointer and turns push and pop requests of 8-bit or 16-bit values into a short run of byte-wide memory accesses. A one-cycle request, taken while the engine is idle, names the direction, the size and, for a push, the value. The engine then drives one byte access per clock on a simple byte memory port. A combinational read port supplies the read byte in the same cycle. The engine raises `done` for one cycle when it finishes.

A mode input, sampled when the request is taken, selects between two pointer conventions. In the free-slot convention the pointer addresses the next empty byte. In the top-of-stack convention it addresses the byte most recently pushed. In both conventions a 16-bit value is stored big-endian, with the high byte at the lower address. A separate load port writes the pointer directly, but only while no operation is in flight.

Top module: `stack_engine`

## Requirements
- R1: While reset is asserted and after it is released, `sp` equals the RESET_SP parameter (default 0x0100), `pop_data` is 0, and `busy`, `done` and `mem_we` are 0.
- R2: With `mode_last_used`=0 (free-slot), a byte push (`req_push`=1, `req_wide`=0) writes `req_data[7:0]` at address SP and leaves SP-1.
- R3: With `mode_last_used`=0, a word push (`req_wide`=1) writes `req_data[15:8]` at SP-1, then `req_data[7:0]` at SP, and leaves SP-2.
- R4: With `mode_last_used`=0, a byte pop (`req_push`=0) reads SP+1 and leaves SP+1. A word pop reads the high byte at SP+1 and the low byte at SP+2, and leaves SP+2.
- R5: With `mode_last_used`=1 (top-of-stack), a byte push writes at SP-1 and leaves SP-1. A word push writes the high byte at SP-2 and the low byte at SP-1, and leaves SP-2.
- R6: With `mode_last_used`=1, a byte pop reads SP and a word pop reads the high byte at SP and the low byte at SP+1. Either pop then adds its size in bytes to SP.
- R7: A request is taken on the clock edge that ends an idle cycle with `req`=1. Byte accesses then follow, one per clock, with `busy`=1 and `mem_we`=1 for pushes only. In the cycle after the last access, `done`=1 for one cycle, `busy`=0 and `sp` shows its new value. A byte pop returns its byte zero-extended on `pop_data`. `pop_data` holds the last popped value until the next pop completes.
- R8: All pointer and address arithmetic wraps modulo 2^16.
- R9: `sp_load`=1 in an idle cycle makes `sp` equal `sp_load_val` in the next cycle. During a busy cycle `sp_load` has no effect.
- R10: When `sp_load` and `req` are both 1 in the same idle cycle, the load is performed and the request is dropped.
- R11: `req` during a busy cycle is ignored. It starts no second operation.
- R12: The mode, direction, size and data are captured when the request is taken. Changing them while the engine is busy does not alter the operation in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_last_used | input | 1 | 0: pointer addresses the free slot; 1: pointer addresses the last pushed byte |
| req | input | 1 | Start an operation (taken only when idle) |
| req_push | input | 1 | 1 push, 0 pop |
| req_wide | input | 1 | 1 for 16-bit value, 0 for 8-bit |
| req_data | input | 16 | Value to push |
| sp_load | input | 1 | Load the pointer directly |
| sp_load_val | input | 16 | Value for a direct load |
| busy | output | 1 | A byte access is in progress this cycle |
| done | output | 1 | One-cycle completion pulse |
| pop_data | output | 16 | Last popped value |
| sp | output | 16 | Current stack pointer |
| mem_addr | output | 16 | Byte address of the current access |
| mem_wdata | output | 8 | Byte to write |
| mem_we | output | 1 | Write enable for the current access |
| mem_rdata | input | 8 | Byte read from `mem_addr` in the same cycle |

## Verification
The checker watches the cycle-level rules on every clock. It confirms that writes occur only while busy and that the two accesses of a word sit at adjacent rising addresses. It also confirms that an operation lasts no more than two access cycles, that `done` follows the fall of `busy` as a single pulse, and that the pointer moves only on completion or on an idle load. The exact addresses under each convention, the byte order, the popped values, wrap-around at the ends of the address space and the load-versus-request priority can only be shown by the bench scenarios. The bench's reference model computes these from the rules and compares them every cycle.

// File: rtl/stk_pkg.sv
package stk_pkg;

    // Number of bytes in the wide (16-bit) value.
    localparam int WORD_BYTES = 2;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_B0   = 2'd1,
        ST_B1   = 2'd2
    } stk_state_e;

    typedef struct packed {
        logic last_used;
        logic push;
        logic wide;
    } stk_cmd_t;

endpackage

// File: rtl/stk_addr_calc.sv
// First-byte address and resulting pointer for one operation.
module stk_addr_calc #(
    parameter int ADDR_W = 16
) (
    input  logic [ADDR_W-1:0] sp_i,
    input  stk_pkg::stk_cmd_t cmd_i,
    output logic [ADDR_W-1:0] base_o,
    output logic [ADDR_W-1:0] next_sp_o
);
    logic [ADDR_W-1:0] size;

    always_comb begin
        size = cmd_i.wide ? ADDR_W'(2) : ADDR_W'(1);
        if (cmd_i.push) begin
            next_sp_o = sp_i - size;
            // top-of-stack: write at the new pointer; free-slot: one above it
            base_o    = cmd_i.last_used ? next_sp_o : next_sp_o + ADDR_W'(1);
        end else begin
            next_sp_o = sp_i + size;
            base_o    = cmd_i.last_used ? sp_i : sp_i + ADDR_W'(1);
        end
    end
endmodule

// File: rtl/stk_byte_lane.sv
// Byte lane steering: picks the outgoing byte and merges the incoming one.
module stk_byte_lane #(
    parameter int BYTE_W = 8,
    parameter int LANES  = stk_pkg::WORD_BYTES
) (
    input  logic [LANES*BYTE_W-1:0] word_i,
    input  logic [BYTE_W-1:0]       rdata_i,
    input  logic                    second_i,
    input  logic                    wide_i,
    output logic [LANES*BYTE_W-1:0] merged_o,
    output logic [BYTE_W-1:0]       wr_byte_o
);
    localparam int IDXW = (LANES > 1) ? $clog2(LANES) : 1;

    logic [IDXW-1:0] target;

    // Big-endian: first access carries the most significant lane.
    always_comb begin
        if (wide_i)
            target = IDXW'(LANES - 1) - IDXW'(second_i);
        else
            target = '0;
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign merged_o[g*BYTE_W +: BYTE_W] =
            (target == IDXW'(g)) ? rdata_i : word_i[g*BYTE_W +: BYTE_W];
    end

    always_comb begin
        wr_byte_o = '0;
        for (int l = 0; l < LANES; l++) begin
            if (target == IDXW'(l))
                wr_byte_o = word_i[l*BYTE_W +: BYTE_W];
        end
    end
endmodule

// File: rtl/stk_seq.sv
// Sequencer: accepts a request, steps byte accesses, completes the pointer.
module stk_seq #(
    parameter int                ADDR_W   = 16,
    parameter int                BYTE_W   = 8,
    parameter logic [ADDR_W-1:0] RESET_SP = 16'h0100
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   req_i,
    input  stk_pkg::stk_cmd_t      cmd_i,
    input  logic [2*BYTE_W-1:0]    data_i,
    input  logic                   load_i,
    input  logic [ADDR_W-1:0]      load_val_i,
    input  logic [ADDR_W-1:0]      calc_base_i,
    input  logic [ADDR_W-1:0]      calc_next_i,
    input  logic [2*BYTE_W-1:0]    lane_merged_i,
    input  logic [BYTE_W-1:0]      lane_wr_i,
    output logic [2*BYTE_W-1:0]    lane_word_o,
    output logic                   lane_second_o,
    output logic                   lane_wide_o,
    output logic [ADDR_W-1:0]      sp_o,
    output logic                   busy_o,
    output logic                   done_o,
    output logic [2*BYTE_W-1:0]    pop_o,
    output logic [ADDR_W-1:0]      addr_o,
    output logic [BYTE_W-1:0]      wdata_o,
    output logic                   we_o
);
    import stk_pkg::*;

    localparam int DW = 2 * BYTE_W;

    typedef struct packed {
        stk_state_e        state;
        logic              push;
        logic              wide;
        logic [ADDR_W-1:0] addr;
        logic [ADDR_W-1:0] nsp;
        logic [ADDR_W-1:0] sp;
        logic [DW-1:0]     word;
        logic [DW-1:0]     pop;
        logic              done;
    } seq_regs_t;

    seq_regs_t r_q, r_d;

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        unique case (r_q.state)
            ST_IDLE: begin
                if (load_i) begin
                    // direct load wins over a simultaneous request
                    r_d.sp = load_val_i;
                end else if (req_i) begin
                    r_d.state = ST_B0;
                    r_d.push  = cmd_i.push;
                    r_d.wide  = cmd_i.wide;
                    r_d.addr  = calc_base_i;
                    r_d.nsp   = calc_next_i;
                    r_d.word  = cmd_i.push ? data_i : '0;
                end
            end
            ST_B0, ST_B1: begin
                if (!r_q.push)
                    r_d.word = lane_merged_i;
                if (r_q.state == ST_B0 && r_q.wide) begin
                    r_d.state = ST_B1;
                    r_d.addr  = r_q.addr + ADDR_W'(1);
                end else begin
                    r_d.state = ST_IDLE;
                    r_d.done  = 1'b1;
                    r_d.sp    = r_q.nsp;
                    if (!r_q.push)
                        r_d.pop = lane_merged_i;
                end
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.state <= ST_IDLE;
            r_q.push  <= 1'b0;
            r_q.wide  <= 1'b0;
            r_q.addr  <= '0;
            r_q.nsp   <= RESET_SP;
            r_q.sp    <= RESET_SP;
            r_q.word  <= '0;
            r_q.pop   <= '0;
            r_q.done  <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign busy_o        = (r_q.state != ST_IDLE);
    assign lane_word_o   = r_q.word;
    assign lane_second_o = (r_q.state == ST_B1);
    assign lane_wide_o   = r_q.wide;
    assign sp_o          = r_q.sp;
    assign done_o        = r_q.done;
    assign pop_o         = r_q.pop;
    assign addr_o        = r_q.addr;
    assign we_o          = busy_o && r_q.push;
    assign wdata_o       = lane_wr_i;
endmodule

// File: rtl/stack_engine.sv
module stack_engine #(
    parameter int                ADDR_W   = 16,
    parameter int                BYTE_W   = 8,
    parameter logic [ADDR_W-1:0] RESET_SP = 16'h0100
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                mode_last_used,
    input  logic                req,
    input  logic                req_push,
    input  logic                req_wide,
    input  logic [2*BYTE_W-1:0] req_data,
    input  logic                sp_load,
    input  logic [ADDR_W-1:0]   sp_load_val,
    output logic                busy,
    output logic                done,
    output logic [2*BYTE_W-1:0] pop_data,
    output logic [ADDR_W-1:0]   sp,
    output logic [ADDR_W-1:0]   mem_addr,
    output logic [BYTE_W-1:0]   mem_wdata,
    output logic                mem_we,
    input  logic [BYTE_W-1:0]   mem_rdata
);
    import stk_pkg::*;

    localparam int DW = 2 * BYTE_W;

    stk_cmd_t          cmd;
    logic [ADDR_W-1:0] calc_base, calc_next;
    logic [DW-1:0]     lane_word, lane_merged;
    logic [BYTE_W-1:0] lane_wr;
    logic              lane_second, lane_wide;

    assign cmd = '{last_used: mode_last_used, push: req_push, wide: req_wide};

    stk_addr_calc #(.ADDR_W(ADDR_W)) u_calc (
        .sp_i      (sp),
        .cmd_i     (cmd),
        .base_o    (calc_base),
        .next_sp_o (calc_next)
    );

    stk_byte_lane #(.BYTE_W(BYTE_W), .LANES(WORD_BYTES)) u_lane (
        .word_i    (lane_word),
        .rdata_i   (mem_rdata),
        .second_i  (lane_second),
        .wide_i    (lane_wide),
        .merged_o  (lane_merged),
        .wr_byte_o (lane_wr)
    );

    stk_seq #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W), .RESET_SP(RESET_SP)) u_seq (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_i         (req),
        .cmd_i         (cmd),
        .data_i        (req_data),
        .load_i        (sp_load),
        .load_val_i    (sp_load_val),
        .calc_base_i   (calc_base),
        .calc_next_i   (calc_next),
        .lane_merged_i (lane_merged),
        .lane_wr_i     (lane_wr),
        .lane_word_o   (lane_word),
        .lane_second_o (lane_second),
        .lane_wide_o   (lane_wide),
        .sp_o          (sp),
        .busy_o        (busy),
        .done_o        (done),
        .pop_o         (pop_data),
        .addr_o        (mem_addr),
        .wdata_o       (mem_wdata),
        .we_o          (mem_we)
    );
endmodule

// File: rtl/stk_chk.sv
module stk_chk #(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              done,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [ADDR_W-1:0] sp,
    input logic              sp_load
);
    logic past_ok;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    // R7
    we_when_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> busy);

    // R7
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R7
    done_not_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R7
    done_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $fell(busy)) |-> done);

    // R3
    addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && busy && $past(busy)) |-> (mem_addr == $past(mem_addr) + ADDR_W'(1)));

    // R11
    max_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && busy && $past(busy)) |=> !busy);

    // R9
    sp_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && sp != $past(sp)) |-> (done || $past(sp_load && !busy)));
endmodule

bind stack_engine stk_chk #(.ADDR_W(ADDR_W)) u_stk_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .busy     (busy),
    .done     (done),
    .mem_we   (mem_we),
    .mem_addr (mem_addr),
    .sp       (sp),
    .sp_load  (sp_load)
);

// File: tb/test_stack_engine.sv
`timescale 1ns/1ps
module test_stack_engine;
    localparam logic [15:0] RST_SP = 16'h0100;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mode_last_used = 1'b0, req = 1'b0, req_push = 1'b0, req_wide = 1'b0;
    logic [15:0] req_data = '0, sp_load_val = '0;
    logic        sp_load = 1'b0;
    logic        busy, done, mem_we;
    logic [15:0] pop_data, sp, mem_addr;
    logic [7:0]  mem_wdata, mem_rdata;

    always #10 clk = ~clk;

    stack_engine #(.RESET_SP(RST_SP)) i_stack_engine (
        .clk(clk), .rst_n(rst_n), .mode_last_used(mode_last_used), .req(req),
        .req_push(req_push), .req_wide(req_wide), .req_data(req_data),
        .sp_load(sp_load), .sp_load_val(sp_load_val), .busy(busy), .done(done),
        .pop_data(pop_data), .sp(sp), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_we(mem_we), .mem_rdata(mem_rdata)
    );

    // Bench RAM (256 bytes, indexed by the low address byte)
    logic [7:0] ram [0:255];
    initial for (int i = 0; i < 256; i++) ram[i] = 8'h00;
    assign mem_rdata = ram[mem_addr[7:0]];
    always @(posedge clk) if (mem_we) ram[mem_addr[7:0]] <= mem_wdata;

    // Reference model state
    logic [7:0]  ref_mem [0:255];
    initial for (int i = 0; i < 256; i++) ref_mem[i] = 8'h00;
    logic [15:0] plan_sp = RST_SP, plan_pop = '0;
    logic [15:0] model_sp = RST_SP, model_pop = '0;

    typedef struct {
        bit          busy;
        bit          we;
        bit          done;
        logic [15:0] addr;
        logic [7:0]  wdata;
        logic [15:0] sp;
        logic [15:0] pop;
        string       tag;
    } rec_t;
    rec_t q[$];

    int  checks = 0, fails = 0;
    bit  run = 1'b0;
    bit  finished = 1'b0;

    task automatic ck(string tag, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h at %0t", tag, what, act, exp, $time);
        end
    endtask

    // Compare every clock, away from the active edge
    always @(negedge clk) begin
        if (run) begin
            rec_t r;
            if (q.size() > 0) r = q.pop_front();
            else begin
                r.busy = 0; r.we = 0; r.done = 0; r.addr = '0; r.wdata = '0;
                r.sp = model_sp; r.pop = model_pop; r.tag = "R7/idle";
            end
            ck(r.tag, "busy", 32'(busy), 32'(r.busy));
            ck(r.tag, "done", 32'(done), 32'(r.done));
            ck(r.tag, "we", 32'(mem_we), 32'(r.we));
            ck(r.tag, "sp", 32'(sp), 32'(r.sp));
            ck(r.tag, "pop_data", 32'(pop_data), 32'(r.pop));
            if (r.busy) ck(r.tag, "addr", 32'(mem_addr), 32'(r.addr));
            if (r.we)   ck(r.tag, "wdata", 32'(mem_wdata), 32'(r.wdata));
            model_sp  = r.sp;
            model_pop = r.pop;
        end
    end

    function automatic rec_t mk(bit b, bit w, bit d, logic [15:0] a, logic [7:0] wd,
                                logic [15:0] s, logic [15:0] p, string t);
        rec_t r;
        r.busy = b; r.we = w; r.done = d; r.addr = a; r.wdata = wd;
        r.sp = s; r.pop = p; r.tag = t;
        return r;
    endfunction

    task automatic tick();
        @(negedge clk); #1;
    endtask

    // One operation; options: hold req longer, flip inputs mid-op, load while busy
    task automatic op(bit lu, bit p, bit w, logic [15:0] val, string tag,
                      int hold = 1, bit disturb = 0, bit load_busy = 0);
        logic [15:0] s0, nsp, a_hi, a_lo, a_b, pv;
        int len;
        s0  = plan_sp;
        len = w ? 3 : 2;
        if (p) begin
            nsp = w ? s0 - 16'd2 : s0 - 16'd1;
            if (!lu) begin a_b = s0;         a_hi = s0 - 16'd1; a_lo = s0;         end
            else     begin a_b = s0 - 16'd1; a_hi = s0 - 16'd2; a_lo = s0 - 16'd1; end
        end else begin
            nsp = w ? s0 + 16'd2 : s0 + 16'd1;
            if (!lu) begin a_b = s0 + 16'd1; a_hi = s0 + 16'd1; a_lo = s0 + 16'd2; end
            else     begin a_b = s0;         a_hi = s0;         a_lo = s0 + 16'd1; end
        end
        pv = plan_pop;
        if (w) begin
            if (!p) pv = {ref_mem[a_hi[7:0]], ref_mem[a_lo[7:0]]};
            q.push_back(mk(1, p, 0, a_hi, val[15:8], s0, plan_pop, tag));
            q.push_back(mk(1, p, 0, a_lo, val[7:0],  s0, plan_pop, tag));
            if (p) begin ref_mem[a_hi[7:0]] = val[15:8]; ref_mem[a_lo[7:0]] = val[7:0]; end
        end else begin
            if (!p) pv = {8'h00, ref_mem[a_b[7:0]]};
            q.push_back(mk(1, p, 0, a_b, val[7:0], s0, plan_pop, tag));
            if (p) ref_mem[a_b[7:0]] = val[7:0];
        end
        q.push_back(mk(0, 0, 1, '0, '0, nsp, pv, tag));
        plan_sp = nsp; plan_pop = pv;

        mode_last_used = lu; req_push = p; req_wide = w; req_data = val; req = 1;
        tick();
        if (disturb) begin
            mode_last_used = ~lu; req_push = ~p; req_wide = ~w; req_data = ~val;
        end
        if (load_busy) begin sp_load = 1; sp_load_val = 16'h7777; end
        for (int i = 1; i < hold; i++) tick();
        req = 0;
        if (load_busy) begin tick(); sp_load = 0; end
        while (q.size() > 0) tick();
    endtask

    task automatic load(logic [15:0] v, string tag, bit with_req = 0);
        sp_load = 1; sp_load_val = v;
        if (with_req) begin req = 1; req_push = 1; req_wide = 1; req_data = 16'hDEAD; end
        q.push_back(mk(0, 0, 0, '0, '0, v, plan_pop, tag));
        plan_sp = v;
        tick();
        sp_load = 0; req = 0;
        tick();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: state under reset
        ck("R1", "sp", 32'(sp), 32'(RST_SP));
        ck("R1", "busy", 32'(busy), 0);
        ck("R1", "done", 32'(done), 0);
        ck("R1", "we", 32'(mem_we), 0);
        ck("R1", "pop_data", 32'(pop_data), 0);
        #1 rst_n = 1;
        run = 1;
        repeat (2) tick();

        // Free-slot convention
        load(16'h0180, "R9");
        op(0, 1, 0, 16'h00A5, "R2");
        op(0, 1, 1, 16'h1234, "R3");
        op(0, 0, 1, 16'h0000, "R4");
        op(0, 0, 0, 16'h0000, "R4");
        tick();
        // Top-of-stack convention, back-to-back requests
        load(16'h0140, "R9");
        op(1, 1, 0, 16'h005A, "R5");
        op(1, 1, 1, 16'hBEEF, "R5");
        op(1, 0, 1, 16'h0000, "R6");
        op(1, 0, 0, 16'h0000, "R6");
        // Wrap-around
        load(16'h0000, "R8");
        op(0, 1, 1, 16'hC3D2, "R8");
        op(0, 0, 1, 16'h0000, "R8");
        load(16'h0001, "R8");
        op(1, 1, 1, 16'h9ABC, "R8");
        op(1, 0, 1, 16'h0000, "R8");
        op(1, 1, 0, 16'h0066, "R8");
        op(1, 0, 0, 16'h0000, "R8");
        // Load while busy is ignored
        load(16'h0160, "R9");
        op(1, 1, 1, 16'h4455, "R9", 1, 0, 1);
        tick();
        // Load and request in the same idle cycle
        load(16'h0170, "R10", 1);
        tick();
        // Request held into busy cycles
        op(0, 1, 1, 16'h6789, "R11", 2);
        op(0, 0, 0, 16'h0000, "R11", 2);
        // Inputs changed mid-operation
        op(1, 1, 1, 16'h0F1E, "R12", 1, 1);
        op(1, 0, 1, 16'h0000, "R12", 1, 1);
        repeat (3) tick();
        run = 0;
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule